// File: doc/BRIEF.md
# Multiplexed Switch Scanner with Time-Shared Debounce

This block reads sixteen mechanical switch lines through one external 16-to-1 multiplexer. It drives the multiplexer select lines and reads back one data pin. It moves to the next channel after a fixed number of clocks. Near the end of each dwell it takes one synchronized sample of the returned line. That sample goes to a single debounce datapath. The datapath fetches the addressed channel's stability counter from a small counter bank, updates it and writes it back. The accepted level of each channel is held in a sixteen-bit register.

A separate timer republishes the accepted levels at a fixed interval. At each refresh it raises a one-clock strobe and publishes, per channel, a flag that marks a bit that differs from the value published at the previous refresh. Software or downstream logic only needs to act on the strobe.

The scan sequencer has two named states. `S_DWELL` waits while the multiplexer output settles. `S_SAMPLE` lasts one clock: it captures the line and steps the select. Its transitions are DWELL_DONE (`S_DWELL` to `S_SAMPLE`, taken when the dwell count reaches DWELL-2) and NEXT_CH (`S_SAMPLE` to `S_DWELL`, taken unconditionally).

Top module: `mux_debounce_scanner`

## Requirements
- R1: `mux_sel_o` is a channel index that holds for exactly DWELL clocks, then increments by one, wrapping from N_CH-1 to 0.
- R2: The returned line passes through a two-flop synchronizer. It is sampled once per dwell, in the dwell's last clock, so each channel is read once every N_CH*DWELL clocks.
- R3: A channel's accepted level changes only after STABLE consecutive samples that disagree with it. A new level held for STABLE+1 visits is always accepted, and a shorter excursion of at most STABLE-1 samples is rejected.
- R4: A sample that agrees with the accepted level clears that channel's counter, so separate short disagreements never add up to a change.
- R5: `update_o` is high for exactly one clock, once every UPD_CLKS clocks.
- R6: At each `update_o` the vector `level_o` takes the accepted levels (bit i = channel i, 1 = line high). `level_o` holds between strobes.
- R7: At each `update_o`, bit i of `changed_o` is 1 exactly when bit i of the new `level_o` differs from the value it had before that strobe. It is all zero after a refresh with no change.
- R8: After reset the select is 0, `update_o` is low, and `level_o`, `changed_o` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_sel_o | output | $clog2(N_CH) | Select lines to the external multiplexer |
| mux_line_i | input | 1 | Data returned by the multiplexer |
| level_o | output | N_CH | Published debounced levels |
| changed_o | output | N_CH | Per-channel change flags since the last refresh |
| update_o | output | 1 | One-clock refresh strobe |

## Verification
The select changes DWELL clocks after the previous change. The bench measures this interval at falling edges. `level_o` and `changed_o` are written on the same edge that raises `update_o`, so every data check waits for the rising strobe and reads at the next falling edge. A new switch pattern needs at most (STABLE+1)*N_CH*DWELL clocks plus two synchronizer clocks to settle. The bench applies each pattern right after a strobe, with UPD_CLKS larger than that bound, so the following strobe must already show it. Rejection tests keep each excursion to two visit periods and finish well inside one refresh interval.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic {
        S_DWELL  = 1'b0,
        S_SAMPLE = 1'b1
    } scan_state_t;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int DWELL = 32,
    localparam int AW   = $clog2(N_CH),
    localparam int DW_W = $clog2(DWELL)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [AW-1:0] sel_o,
    output logic          strobe_o
);
    scan_state_t state_q, state_d;
    logic [DW_W-1:0] dwell_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DWELL:  if (dwell_q == DW_W'(DWELL - 2)) state_d = S_SAMPLE; // DWELL_DONE
            S_SAMPLE: state_d = S_DWELL;                                    // NEXT_CH
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_DWELL;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dwell_q <= '0;
            sel_o   <= '0;
        end else if (state_q == S_SAMPLE) begin
            dwell_q <= '0;
            sel_o   <= (sel_o == AW'(N_CH - 1)) ? '0 : sel_o + 1'b1;
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    assign strobe_o = (state_q == S_SAMPLE);

    AST_SEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> (sel_o == (($past(sel_o) == AW'(N_CH - 1)) ? '0 : $past(sel_o) + 1'b1))); // R1
    AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_o |=> $stable(sel_o)); // R1
endmodule

// File: rtl/sync2.sv
module sync2 (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            q_o    <= 1'b0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/deb_bank.sv
module deb_bank #(
    parameter int N_CH   = 16,
    parameter int STABLE = 4096,
    localparam int AW    = $clog2(N_CH),
    localparam int CW    = $clog2(STABLE)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            strobe_i,
    input  logic [AW-1:0]   ch_i,
    input  logic            sample_i,
    output logic [N_CH-1:0] level_o
);
    logic [CW-1:0] cnt_mem [N_CH];
    logic [CW-1:0] rd_cnt;
    logic          cur_lvl;

    assign rd_cnt  = cnt_mem[ch_i];
    assign cur_lvl = level_o[ch_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < N_CH; i++) cnt_mem[i] <= '0;
            level_o <= '0;
        end else if (strobe_i) begin
            if (sample_i == cur_lvl) begin
                cnt_mem[ch_i] <= '0;
            end else if (rd_cnt == CW'(STABLE - 1)) begin
                cnt_mem[ch_i] <= '0;
                level_o[ch_i] <= sample_i;
            end else begin
                cnt_mem[ch_i] <= rd_cnt + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |-> (rd_cnt <= CW'(STABLE - 1))); // R3
    AST_ONE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(level_o ^ $past(level_o)) <= 1); // R3
    AST_AGREE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && (sample_i == cur_lvl)) |=> $stable(level_o)); // R4
endmodule

// File: rtl/upd_gen.sv
module upd_gen #(
    parameter int N_CH     = 16,
    parameter int UPD_CLKS = 1000000,
    localparam int TW      = $clog2(UPD_CLKS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_CH-1:0] level_i,
    output logic [N_CH-1:0] level_o,
    output logic [N_CH-1:0] changed_o,
    output logic            update_o
);
    logic [TW-1:0] tmr_q;
    logic          tick;

    assign tick = (tmr_q == TW'(UPD_CLKS - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tick ? '0 : tmr_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_o   <= '0;
            changed_o <= '0;
            update_o  <= 1'b0;
        end else begin
            update_o <= tick;
            if (tick) begin
                level_o   <= level_i;
                changed_o <= level_i ^ level_o;
            end
        end
    end

    AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        update_o |=> !update_o); // R5
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !update_o |-> ($stable(level_o) && $stable(changed_o))); // R6
endmodule

// File: rtl/mux_debounce_scanner.sv
module mux_debounce_scanner #(
    parameter int N_CH     = 16,
    parameter int DWELL    = 32,
    parameter int STABLE   = 4096,
    parameter int UPD_CLKS = 1000000,
    localparam int AW      = $clog2(N_CH)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output logic [AW-1:0]   mux_sel_o,
    input  logic            mux_line_i,
    output logic [N_CH-1:0] level_o,
    output logic [N_CH-1:0] changed_o,
    output logic            update_o
);
    logic            strobe;
    logic            line_s;
    logic [N_CH-1:0] accepted;

    scan_seq #(.N_CH(N_CH), .DWELL(DWELL)) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_o(mux_sel_o), .strobe_o(strobe)
    );

    sync2 u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mux_line_i), .q_o(line_s)
    );

    deb_bank #(.N_CH(N_CH), .STABLE(STABLE)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe), .ch_i(mux_sel_o),
        .sample_i(line_s), .level_o(accepted)
    );

    upd_gen #(.N_CH(N_CH), .UPD_CLKS(UPD_CLKS)) u_upd (
        .clk_i(clk_i), .rst_ni(rst_ni), .level_i(accepted),
        .level_o(level_o), .changed_o(changed_o), .update_o(update_o)
    );
endmodule

// File: tb/mux_debounce_scanner_tb.sv
module mux_debounce_scanner_tb;
    localparam int N_CH = 16, DWELL = 4, STABLE = 4, UPD_CLKS = 1000;
    localparam int AW = $clog2(N_CH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   sel;
    logic            line;
    logic [N_CH-1:0] level, changed;
    logic            upd;
    logic [N_CH-1:0] sw = '0;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;
    assign line = sw[sel];

    mux_debounce_scanner #(.N_CH(N_CH), .DWELL(DWELL), .STABLE(STABLE), .UPD_CLKS(UPD_CLKS)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mux_sel_o(sel), .mux_line_i(line),
        .level_o(level), .changed_o(changed), .update_o(upd)
    );

    function automatic logic [N_CH-1:0] exp_flags(logic [N_CH-1:0] nw, logic [N_CH-1:0] old);
        return nw ^ old;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_upd();
        @(posedge upd);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [N_CH-1:0] prev, g;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk("R8 sel", 32'(sel), 0);
        chk("R8 update", 32'(upd), 0);
        chk("R8 level", 32'(level), 0);
        chk("R8 changed", 32'(changed), 0);
        rst_n = 1'b1;

        // R1: select dwell and step
        for (int k = 0; k < 20; k++) begin
            logic [AW-1:0] s0;
            int n;
            s0 = sel;
            n = 0;
            while (sel == s0) begin @(negedge clk); n++; end
            if (k > 0) chk("R1 dwell", 32'(n), DWELL);
            chk("R1 step", 32'(sel), 32'((s0 + 1) % N_CH));
        end

        // R5: pulse width and period
        wait_upd();
        chk("R5 high", 32'(upd), 1);
        @(negedge clk);
        chk("R5 one clock", 32'(upd), 0);
        begin
            int n;
            n = 1;
            while (!upd) begin @(negedge clk); n++; end
            chk("R5 period", 32'(n), UPD_CLKS);
        end

        // R2 R6 R7: directed and random patterns applied right after a strobe
        prev = '0;
        for (int k = 0; k < 12; k++) begin
            if (k == 0) sw = '1;
            else if (k == 1) sw = '0;
            else sw = N_CH'($urandom);
            wait_upd();
            chk("R6 level", 32'(level), 32'(sw));
            chk("R7 flags", 32'(changed), 32'(exp_flags(sw, prev)));
            prev = sw;
            wait_upd();
            chk("R7 no change", 32'(changed), 0);
            chk("R6 level held", 32'(level), 32'(sw));
        end

        // R3: single short excursion is rejected
        for (int k = 0; k < 3; k++) begin
            g = prev ^ (N_CH'(1) << ($urandom % N_CH));
            sw = g;
            repeat (2 * N_CH * DWELL) @(negedge clk);
            sw = prev;
            wait_upd();
            chk("R3 reject level", 32'(level), 32'(prev));
            chk("R3 reject flags", 32'(changed), 0);
        end

        // R4: two excursions split by agreement do not accumulate
        for (int k = 0; k < 3; k++) begin
            g = prev ^ (N_CH'(1) << ($urandom % N_CH));
            sw = g;
            repeat (2 * N_CH * DWELL) @(negedge clk);
            sw = prev;
            repeat (2 * N_CH * DWELL) @(negedge clk);
            sw = g;
            repeat (2 * N_CH * DWELL) @(negedge clk);
            sw = prev;
            wait_upd();
            chk("R4 reject level", 32'(level), 32'(prev));
            chk("R4 reject flags", 32'(changed), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule